// File: doc/BRIEF.md
# Multi-Mode Signed/Unsigned Multiplier

This block is the multiply unit of a 16-bit coprocessor datapath. One request carries a source word, a multiplier word, a two-bit operation code and a speed bit. It supports four operations. Two are short byte multiplies, one signed and one unsigned, each giving a 16-bit result. The other two are 16×16 signed multiplies: one returns the product split into an upper and a lower word, and the other returns a Q15 fractional result. The unit also produces sign, zero and carry flags.

Requests enter on a valid/ready handshake. `in_ready` is low from the cycle after a request is accepted until its result is delivered. A requester holding `in_valid` high simply waits, and its operands are not sampled until the handshake completes. Operands, operation and speed are captured at acceptance, so later changes on those inputs have no effect. The result is a one-cycle `done` strobe. The result words and flags stay registered and unchanged until the next strobe. The latency depends on the operation and the speed bit, and each latency is a parameter. Selecting which register-file entries receive the words is left to the surrounding datapath. In long mode the upper word is meant for the destination register and the lower word for a fixed auxiliary register.

Top module: `mulx_unit`

## Requirements
- R1: Operation code 0 (short signed) multiplies bits 7:0 of the source and bits 7:0 of the multiplier as two's-complement bytes, and delivers the 16-bit signed product on `res_dst`.
- R2: Operation code 1 (short unsigned) multiplies the same two bytes as unsigned values and delivers the 16-bit product on `res_dst`.
- R3: Operation code 2 (long) multiplies the two full words as signed 16-bit values. Bits 31:16 of the product go on `res_dst` and bits 15:0 on `res_aux`, with `aux_we` high. In every other mode, `res_aux` reads 0 and `aux_we` is low.
- R4: Operation code 3 (fractional) forms the signed 32-bit product, shifts it left by one bit, delivers bits 31:16 of the shifted value on `res_dst`, and sets carry to bit 15 of the shifted value.
- R5: `flag_s` equals bit 15 of `res_dst`, and `flag_z` is high exactly when `res_dst` is 0. `flag_c` is bit 15 of the product in long mode and follows R4 in fractional mode. It is 0 in both short modes.
- R6: The `done` strobe comes N rising edges after the accepting edge. With the speed bit low, N is 2 for the short modes, 9 for long and 8 for fractional. With the speed bit high, N is 1, 5 and 4 respectively.
- R7: Once a request is accepted, `in_ready` stays low until `done` is shown. `in_ready` is high whenever `done` is high, so a new request can be accepted in the strobe cycle.
- R8: `done` lasts exactly one cycle. The result words and flags do not change between strobes.
- R9: After reset, `in_ready` is 1, `done` is 0, and all result words and flags are 0.
- R10: In the short modes, bits 15:8 of both operands have no effect on the result.
- R11: Changes to operands, operation code or speed bit after the accepting edge do not affect the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_op | input | 2 | Operation: 0 short signed, 1 short unsigned, 2 long, 3 fractional |
| in_fast | input | 1 | Speed bit: 1 selects the shorter latencies |
| in_src | input | 16 | Source operand |
| in_mplr | input | 16 | Multiplier operand |
| done | output | 1 | One-cycle result strobe |
| res_dst | output | 16 | Destination result word |
| res_aux | output | 16 | Low product word in long mode, else 0 |
| aux_we | output | 1 | High when `res_aux` is meaningful |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The completion strobe for one request and the acceptance of the next can occur in the same cycle. The bench provokes this by raising `in_valid` in the very cycle in which `done` shows a long-mode result. It then checks three things on the next edge: the strobe has fallen, `in_ready` has dropped, and the previous result words are unchanged. The bench also holds a second request on `in_valid` through a whole fractional operation. That request must be accepted only in the strobe cycle, must leave the fractional result untouched, and must then finish with its own latency.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
  typedef enum logic [1:0] {
    OP_SMUL = 2'd0,
    OP_UMUL = 2'd1,
    OP_LMUL = 2'd2,
    OP_QMUL = 2'd3
  } mulx_op_e;
endpackage

// File: rtl/mulx_lat.sv
// Picks the countdown load value (latency minus one) from mode and speed.
module mulx_lat
  import mulx_pkg::*;
#(
  parameter int CW            = 4,
  parameter int LAT_SHORT_STD = 2,
  parameter int LAT_SHORT_HS  = 1,
  parameter int LAT_LONG_STD  = 9,
  parameter int LAT_LONG_HS   = 5,
  parameter int LAT_FRAC_STD  = 8,
  parameter int LAT_FRAC_HS   = 4
) (
  input  mulx_op_e        op,
  input  logic            fast,
  output logic [CW-1:0]   load
);
  always_comb begin
    case (op)
      OP_LMUL: load = fast ? CW'(LAT_LONG_HS - 1)  : CW'(LAT_LONG_STD - 1);
      OP_QMUL: load = fast ? CW'(LAT_FRAC_HS - 1)  : CW'(LAT_FRAC_STD - 1);
      default: load = fast ? CW'(LAT_SHORT_HS - 1) : CW'(LAT_SHORT_STD - 1);
    endcase
  end
endmodule

// File: rtl/mulx_arith.sv
// Combinational product and flag generation for all four modes.
module mulx_arith
  import mulx_pkg::*;
#(
  parameter int DW = 16
) (
  input  mulx_op_e        op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   dst,
  output logic [DW-1:0]   aux,
  output logic            aux_we,
  output logic            s,
  output logic            z,
  output logic            c
);
  localparam int HW = DW / 2;
  localparam int PW = 2 * DW;

  logic [DW-1:0] sxa, sxb, zxa, zxb, sprod, uprod;
  logic [PW-1:0] lxa, lxb, lprod, qprod;

  always_comb begin
    sxa   = {{HW{a[HW-1]}}, a[HW-1:0]};
    sxb   = {{HW{b[HW-1]}}, b[HW-1:0]};
    zxa   = {{HW{1'b0}}, a[HW-1:0]};
    zxb   = {{HW{1'b0}}, b[HW-1:0]};
    sprod = sxa * sxb;
    uprod = zxa * zxb;
    lxa   = {{DW{a[DW-1]}}, a};
    lxb   = {{DW{b[DW-1]}}, b};
    lprod = lxa * lxb;
    qprod = {lprod[PW-2:0], 1'b0};
  end

  always_comb begin
    aux    = '0;
    aux_we = 1'b0;
    c      = 1'b0;
    case (op)
      OP_SMUL: dst = sprod;
      OP_UMUL: dst = uprod;
      OP_LMUL: begin
        dst    = lprod[PW-1:DW];
        aux    = lprod[DW-1:0];
        aux_we = 1'b1;
        c      = lprod[DW-1];
      end
      default: begin
        dst = qprod[PW-1:DW];
        c   = qprod[DW-1];
      end
    endcase
  end

  assign s = dst[DW-1];
  assign z = (dst == '0);
endmodule

// File: rtl/mulx_seq.sv
// Handshake and latency countdown.
module mulx_seq #(
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [CW-1:0]   load,
  output logic            in_ready,
  output logic            accept,
  output logic            fin,
  output logic            done
);
  logic          busy;
  logic [CW-1:0] cnt;

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;
  assign fin      = busy & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= fin;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= load;
      end else if (fin) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
  import mulx_pkg::*;
#(
  parameter int DW            = 16,
  parameter int LAT_SHORT_STD = 2,
  parameter int LAT_SHORT_HS  = 1,
  parameter int LAT_LONG_STD  = 9,
  parameter int LAT_LONG_HS   = 5,
  parameter int LAT_FRAC_STD  = 8,
  parameter int LAT_FRAC_HS   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic          in_fast,
  input  logic [DW-1:0] in_src,
  input  logic [DW-1:0] in_mplr,
  output logic          done,
  output logic [DW-1:0] res_dst,
  output logic [DW-1:0] res_aux,
  output logic          aux_we,
  output logic          flag_s,
  output logic          flag_z,
  output logic          flag_c
);
  localparam int M1   = (LAT_SHORT_STD > LAT_SHORT_HS) ? LAT_SHORT_STD : LAT_SHORT_HS;
  localparam int M2   = (LAT_LONG_STD > LAT_LONG_HS) ? LAT_LONG_STD : LAT_LONG_HS;
  localparam int M3   = (LAT_FRAC_STD > LAT_FRAC_HS) ? LAT_FRAC_STD : LAT_FRAC_HS;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int LMAX = (M12 > M3) ? M12 : M3;
  localparam int CW   = $clog2(LMAX + 1);

  mulx_op_e      op_q;
  logic [DW-1:0] a_q, b_q;
  logic [CW-1:0] load;
  logic          accept, fin;
  logic [DW-1:0] c_dst, c_aux;
  logic          c_we, c_s, c_z, c_c;

  mulx_lat #(
    .CW(CW), .LAT_SHORT_STD(LAT_SHORT_STD), .LAT_SHORT_HS(LAT_SHORT_HS),
    .LAT_LONG_STD(LAT_LONG_STD), .LAT_LONG_HS(LAT_LONG_HS),
    .LAT_FRAC_STD(LAT_FRAC_STD), .LAT_FRAC_HS(LAT_FRAC_HS)
  ) u_lat (
    .op   (mulx_op_e'(in_op)),
    .fast (in_fast),
    .load (load)
  );

  mulx_seq #(.CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .load     (load),
    .in_ready (in_ready),
    .accept   (accept),
    .fin      (fin),
    .done     (done)
  );

  mulx_arith #(.DW(DW)) u_arith (
    .op     (op_q),
    .a      (a_q),
    .b      (b_q),
    .dst    (c_dst),
    .aux    (c_aux),
    .aux_we (c_we),
    .s      (c_s),
    .z      (c_z),
    .c      (c_c)
  );

  // Operand capture at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_SMUL;
      a_q  <= '0;
      b_q  <= '0;
    end else if (accept) begin
      op_q <= mulx_op_e'(in_op);
      a_q  <= in_src;
      b_q  <= in_mplr;
    end
  end

  // Result capture on the final countdown cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_dst <= '0;
      res_aux <= '0;
      aux_we  <= 1'b0;
      flag_s  <= 1'b0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
    end else if (fin) begin
      res_dst <= c_dst;
      res_aux <= c_aux;
      aux_we  <= c_we;
      flag_s  <= c_s;
      flag_z  <= c_z;
      flag_c  <= c_c;
    end
  end
endmodule

// File: rtl/mulx_chk.sv
module mulx_chk #(
  parameter int DW            = 16,
  parameter int LAT_SHORT_STD = 2,
  parameter int LAT_SHORT_HS  = 1,
  parameter int LAT_LONG_STD  = 9,
  parameter int LAT_LONG_HS   = 5,
  parameter int LAT_FRAC_STD  = 8,
  parameter int LAT_FRAC_HS   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_op,
  input logic          in_fast,
  input logic          done,
  input logic [DW-1:0] res_dst,
  input logic [DW-1:0] res_aux,
  input logic          aux_we,
  input logic          flag_s,
  input logic          flag_z,
  input logic          flag_c
);
  function automatic int lat_of(input logic [1:0] op, input logic f);
    case (op)
      2'd2:    return f ? LAT_LONG_HS  : LAT_LONG_STD;
      2'd3:    return f ? LAT_FRAC_HS  : LAT_FRAC_STD;
      default: return f ? LAT_SHORT_HS : LAT_SHORT_STD;
    endcase
  endfunction

  logic armed, waiting, long_q;
  int   wcnt, exp_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      waiting <= 1'b0;
      long_q  <= 1'b0;
      wcnt    <= 0;
      exp_lat <= 0;
    end else begin
      armed <= 1'b1;
      if (in_valid && in_ready) begin
        waiting <= 1'b1;
        wcnt    <= 1;
        exp_lat <= lat_of(in_op, in_fast);
        long_q  <= (in_op == 2'd2);
      end else if (done) begin
        waiting <= 1'b0;
      end else if (waiting) begin
        wcnt <= wcnt + 1;
      end
    end
  end

  p_lat_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !done && wcnt == exp_lat) |=> done);
  p_lat_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !done && wcnt < exp_lat) |=> !done);
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_ready_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !done) |-> ($stable(res_dst) && $stable(res_aux) && $stable(aux_we)
                          && $stable(flag_s) && $stable(flag_z) && $stable(flag_c)));
  p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_s == res_dst[DW-1]));
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == (res_dst == '0)));
  p_aux_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (aux_we == long_q));
endmodule

bind mulx_unit mulx_chk #(
  .DW(DW), .LAT_SHORT_STD(LAT_SHORT_STD), .LAT_SHORT_HS(LAT_SHORT_HS),
  .LAT_LONG_STD(LAT_LONG_STD), .LAT_LONG_HS(LAT_LONG_HS),
  .LAT_FRAC_STD(LAT_FRAC_STD), .LAT_FRAC_HS(LAT_FRAC_HS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_fast(in_fast), .done(done), .res_dst(res_dst),
  .res_aux(res_aux), .aux_we(aux_we), .flag_s(flag_s), .flag_z(flag_z),
  .flag_c(flag_c)
);

// File: tb/sim_mulx_unit.sv
module sim_mulx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic        in_fast = 1'b0;
  logic [15:0] in_src = 16'h0;
  logic [15:0] in_mplr = 16'h0;
  logic        done;
  logic [15:0] res_dst, res_aux;
  logic        aux_we, flag_s, flag_z, flag_c;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mulx_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fast(in_fast), .in_src(in_src), .in_mplr(in_mplr),
    .done(done), .res_dst(res_dst), .res_aux(res_aux), .aux_we(aux_we),
    .flag_s(flag_s), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Arithmetic reference for all modes.
  task automatic model(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic f, output logic [15:0] dst, output logic [15:0] aux,
                       output logic we, output logic c, output int lat);
    longint sa, sb, p;
    logic [31:0] p32, q32;
    aux = 16'h0; we = 1'b0; c = 1'b0;
    case (op)
      2'd0: begin
        sa = longint'(a[7:0]); if (a[7]) sa -= 256;
        sb = longint'(b[7:0]); if (b[7]) sb -= 256;
        p = sa * sb; dst = p[15:0]; lat = f ? 1 : 2;
      end
      2'd1: begin
        p = longint'(a[7:0]) * longint'(b[7:0]); dst = p[15:0]; lat = f ? 1 : 2;
      end
      default: begin
        sa = longint'(a); if (a[15]) sa -= 65536;
        sb = longint'(b); if (b[15]) sb -= 65536;
        p = sa * sb; p32 = p[31:0];
        if (op == 2'd2) begin
          dst = p32[31:16]; aux = p32[15:0]; we = 1'b1; c = p32[15]; lat = f ? 5 : 9;
        end else begin
          q32 = p32 << 1; dst = q32[31:16]; c = q32[15]; lat = f ? 4 : 8;
        end
      end
    endcase
  endtask

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Wait for done; returns edges counted since the accepting edge.
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 64) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic judge(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic f, input int n);
    logic [15:0] ed, ea; logic ew, ec; int el;
    model(op, a, b, f, ed, ea, ew, ec, el);
    chk(tag_of(op), {15'h0, aux_we, res_dst, res_aux}, {15'h0, ew, ed, ea});
    chk("R5", {flag_s, flag_z, flag_c}, {ed[15], ed == 16'h0, ec});
    chk("R6", 64'(n), 64'(el));
  endtask

  // Starts in a post-edge slot, ends in the slot that shows done.
  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic f);
    int n;
    in_valid = 1'b1; in_op = op; in_src = a; in_mplr = b; in_fast = f;
    if (in_ready !== 1'b1) chk("R7", {63'h0, in_ready}, 64'h1);
    @(posedge clk); #1;
    // R11: scramble inputs right after acceptance
    in_valid = 1'b0; in_op = ~op; in_src = ~a; in_mplr = ~b; in_fast = ~f;
    wait_done(n);
    judge(op, a, b, f, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] corners [12];
    logic [15:0] prev;
    int n;
    corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h4000,
                16'hC000, 16'h1234, 16'hEDCB, 16'h00FF, 16'hFF00, 16'h5A5A};
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9", {in_ready, done, res_dst, res_aux, aux_we, flag_s, flag_z, flag_c},
              {1'b1, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Short modes: every source byte against 32 multiplier bytes, with
    // non-zero upper bytes on both operands (R10).
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 32; k++) begin
        logic [7:0] bv;
        logic [15:0] av, bw;
        bv = (k == 0) ? 8'h00 : (k == 1) ? 8'h80 : (k == 2) ? 8'hFF :
             (k == 3) ? 8'h7F : 8'(k * 37 + 5);
        av = {8'(i * 7 + 3), 8'(i)};
        bw = {8'(k * 29 + 1), bv};
        run_op(2'd0, av, bw, 1'((i + k) % 2));
        run_op(2'd1, av, bw, 1'((i + k + 1) % 2));
      end
    end

    // Word modes: all corner pairs in both speed settings.
    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < 12; k++) begin
        for (int f = 0; f < 2; f++) begin
          run_op(2'd2, corners[i], corners[k], 1'(f));
          run_op(2'd3, corners[i], corners[k], 1'(f));
        end
      end
    end

    // Done strobe and new acceptance in the same cycle.
    run_op(2'd2, 16'h1234, 16'h5678, 1'b1);
    chk("R7", {62'h0, done, in_ready}, 64'h3);
    prev = res_dst;
    in_valid = 1'b1; in_op = 2'd3; in_src = 16'h4000; in_mplr = 16'h4000; in_fast = 1'b0;
    @(posedge clk); #1;
    chk("R8", {47'h0, done, res_dst}, {47'h0, 1'b0, prev});
    chk("R7", {63'h0, in_ready}, 64'h0);
    // Hold a pending short request while the fractional one runs (R7, R11).
    in_op = 2'd0; in_src = 16'h33FF; in_mplr = 16'hAA02; in_fast = 1'b1;
    wait_done(n);
    judge(2'd3, 16'h4000, 16'h4000, 1'b0, n);
    chk("R7", {62'h0, done, in_ready}, 64'h3);
    @(posedge clk); #1;
    in_valid = 1'b0;
    wait_done(n);
    judge(2'd0, 16'h33FF, 16'hAA02, 1'b1, n);
    chk("R1", {48'h0, res_dst}, {48'h0, 16'hFFFE});
    @(posedge clk); #1;
    chk("R8", {63'h0, done}, 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule